// File: doc/BRIEF.md
# Glitch-Free System Clock Switcher

This block picks the system clock from up to eight free-running source clocks. Each source has a ready flag. A post-divider then slows the chosen clock by a programmable ratio. Software controls the block through two registers on a single-cycle register port that runs on a control clock. The block produces two outputs: the undivided selected clock and the divided system clock.

A source change is a handshake. Software writes a requested-source code and a start bit. The block first looks at the ready flag of the requested source. If the flag is low, the block refuses the change. It clears the start bit and leaves the current-source field as it was, so software finds the refusal by comparing the two fields. If the flag is high, the block shuts the old clock's gate on that clock's falling edge. It waits until this shutdown is seen in the control domain. It then opens the new clock's gate on the new clock's falling edge. Finally it records the new current source and clears the start bit.

The divider register holds the target ratio, a slew period code and two slew enables, one per direction. It also holds a read-only busy flag. Without slewing, a new ratio takes effect at once. With slewing, the active ratio moves one step per slew period until it reaches the target. Busy stays high until the target is reached. While either the start bit or busy is set, the block ignores writes to both registers.

Top module: `sysclk_switcher`

## Requirements
- R1: After reset, control reads 0 (current source 0, requested source 0, start bit clear) and the divider register reads 0 (ratio field 0 meaning divide-by-1, slew code 0, both slew enables off, busy clear).
- R2: The control register (wr_sel/rd_sel = 0) holds the current source at bits 14:12, the requested source at bits 10:8 and the start bit at bit 0. Writing bit 0 as 1 begins a change to the requested source; on success the start bit clears and the current-source field equals the requested code. A request for the source already in use also completes.
- R3: If the requested source's ready flag is low when the change is examined, the start bit clears, the current-source field keeps its old value, and the requested-source field keeps the new code.
- R4: At most one source gate is open at any time. After a completed change, sys_root_clk has the period of the newly selected source.
- R5: The divider register (wr_sel/rd_sel = 1) holds the ratio minus one at bits 23:20, the slew period code at bits 10:8, the down-scaling slew enable at bit 1, the up-scaling slew enable at bit 2, and the read-only busy flag at bit 0.
- R6: sys_clk rises exactly once every (ratio field + 1) rising edges of sys_root_clk, for every ratio field value 0 to 15.
- R7: With slewing off for the direction taken, an accepted divider write raises busy for 2 control cycles if the ratio changes and for 1 cycle if it does not. The active ratio changes only while busy is set.
- R8: With slewing on for the direction taken, the active ratio moves by one per period of (slew code + 1) × STEP_BASE control cycles. Busy is high for |change| × period + 1 cycles and clears only when the active ratio equals the target.
- R9: A smaller ratio (up-scaling) slews only when bit 2 is set. A larger ratio (down-scaling) slews only when bit 1 is set. When the enable for the direction taken is clear, the ratio jumps.
- R10: While the start bit or busy is set, a write to either register is ignored in full.
- R11: rd_data shows the register chosen by rd_sel one control cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset (also sampled by the source-domain flops) |
| src_clk | input | NSRC | Source clocks |
| src_ready | input | NSRC | Per-source ready flags, control domain |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 divider |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 control, 1 divider |
| rd_data | output | 32 | Registered read data |
| sys_root_clk | output | 1 | Selected, undivided clock |
| sys_clk | output | 1 | Post-divided system clock |

## Verification
A divider write can arrive while a source change is still pending. A change request can arrive while a ratio slew is still running. Both cases meet at the shared lock, which takes effect on the same cycle the collision happens. The bench provokes each case with back-to-back writes: one starts a change or a long slew, and the next write comes two control cycles later. It then judges the outcome by reading both registers back after the first operation ends. The later write must have left no trace, and the first operation must have completed with its expected fields.

// File: rtl/sclk_sw_pkg.sv
`timescale 1ns/1ps
package sclk_sw_pkg;
  localparam int SEL_W    = 3;
  localparam int DIV_W    = 4;
  localparam int SDIV_W   = 3;
  localparam int DATA_W   = 32;
  // control register layout
  localparam int CUR_LSB  = 12;
  localparam int REQ_LSB  = 8;
  localparam int GO_BIT   = 0;
  // divider register layout
  localparam int RATIO_LSB = 20;
  localparam int SPER_LSB  = 8;
  localparam int BUSY_BIT  = 0;
  localparam int DN_BIT    = 1;
  localparam int UP_BIT    = 2;

  typedef enum logic [1:0] {SW_IDLE, SW_DROP, SW_RAISE} sw_state_t;
endpackage

// File: rtl/sclk_gate_cell.sv
`timescale 1ns/1ps
module sclk_gate_cell #(
  parameter bit OPEN_AT_RESET = 1'b0
) (
  input  logic src_clk,
  input  logic rst,
  input  logic open_req,
  output logic gate_en
);
  logic s1, s2;

  always_ff @(posedge src_clk) begin
    if (rst) begin
      s1 <= OPEN_AT_RESET;
      s2 <= OPEN_AT_RESET;
    end else begin
      s1 <= open_req;
      s2 <= s1;
    end
  end

  // enable changes only while the source clock is low
  always_ff @(negedge src_clk) begin
    if (rst) gate_en <= OPEN_AT_RESET;
    else     gate_en <= s2;
  end
endmodule

// File: rtl/sclk_switch_fsm.sv
`timescale 1ns/1ps
module sclk_switch_fsm
  import sclk_sw_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [SEL_W-1:0] req_sel,
  input  logic [NSRC-1:0]  src_ready,
  input  logic [NSRC-1:0]  gate_en,
  output logic [NSRC-1:0]  gate_req,
  output logic [SEL_W-1:0] cur_sel,
  output logic             done,
  output sw_state_t        state
);
  localparam int NEXT = 2 ** SEL_W;

  logic [NSRC-1:0] ack1, ack2;
  logic [NEXT-1:0] rdy_x, ack_x, greq;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack1 <= NSRC'(1);
      ack2 <= NSRC'(1);
    end else begin
      ack1 <= gate_en;
      ack2 <= ack1;
    end
  end

  assign rdy_x    = NEXT'(src_ready);
  assign ack_x    = NEXT'(ack2);
  assign gate_req = greq[NSRC-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SW_IDLE;
      cur_sel <= '0;
      greq    <= NEXT'(1);
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        SW_IDLE: begin
          if (go && !done) begin
            if (!rdy_x[req_sel] || req_sel == cur_sel) begin
              done <= 1'b1;
            end else begin
              greq[cur_sel] <= 1'b0;
              state         <= SW_DROP;
            end
          end
        end
        SW_DROP: begin
          if (!ack_x[cur_sel]) begin
            greq[req_sel] <= 1'b1;
            state         <= SW_RAISE;
          end
        end
        SW_RAISE: begin
          if (ack_x[req_sel]) begin
            cur_sel <= req_sel;
            done    <= 1'b1;
            state   <= SW_IDLE;
          end
        end
        default: state <= SW_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sclk_slew_step.sv
`timescale 1ns/1ps
module sclk_slew_step #(
  parameter int DIV_W     = 4,
  parameter int SDIV_W    = 3,
  parameter int STEP_BASE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DIV_W-1:0]  target,
  input  logic [SDIV_W-1:0] per_code,
  input  logic              up_en,
  input  logic              dn_en,
  output logic [DIV_W-1:0]  ratio_act,
  output logic              busy
);
  localparam int PMAX  = (2 ** SDIV_W) * STEP_BASE;
  localparam int TMR_W = $clog2(PMAX + 1);

  logic [TMR_W-1:0] tmr, per_last;
  logic             faster, slew_on;

  assign per_last = TMR_W'((int'(per_code) + 1) * STEP_BASE - 1);
  assign faster   = target < ratio_act;
  assign slew_on  = faster ? up_en : dn_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_act <= '0;
      busy      <= 1'b0;
      tmr       <= '0;
    end else if (load) begin
      busy <= 1'b1;
      tmr  <= '0;
    end else if (busy) begin
      if (ratio_act == target) begin
        busy <= 1'b0;
      end else if (!slew_on) begin
        ratio_act <= target;
      end else if (tmr == per_last) begin
        tmr       <= '0;
        ratio_act <= faster ? ratio_act - 1'b1 : ratio_act + 1'b1;
      end else begin
        tmr <= tmr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sclk_postdiv.sv
`timescale 1ns/1ps
module sclk_postdiv #(
  parameter int DIV_W = 4
) (
  input  logic             sclk,
  input  logic             rst,
  input  logic [DIV_W-1:0] ratio_in,
  output logic             out_clk
);
  logic [DIV_W-1:0] r1, r2, cnt, cnt_nx;
  logic [DIV_W:0]   hi;
  logic             phase;

  always_ff @(posedge sclk) begin
    if (rst) begin
      r1 <= '0;
      r2 <= '0;
    end else begin
      r1 <= ratio_in;
      r2 <= r1;
    end
  end

  assign cnt_nx = (cnt >= r2) ? '0 : cnt + 1'b1;
  assign hi     = ({1'b0, r2} + (DIV_W+1)'(2)) >> 1;

  always_ff @(posedge sclk) begin
    if (rst) begin
      cnt   <= '0;
      phase <= 1'b1;
    end else begin
      cnt   <= cnt_nx;
      phase <= ({1'b0, cnt_nx} < hi);
    end
  end

  assign out_clk = (r2 == '0) ? sclk : phase;
endmodule

// File: rtl/sysclk_switcher.sv
`timescale 1ns/1ps
module sysclk_switcher
  import sclk_sw_pkg::*;
#(
  parameter int NSRC      = 8,
  parameter int STEP_BASE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_clk,
  input  logic [NSRC-1:0]   src_ready,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              sys_root_clk,
  output logic              sys_clk
);
  logic [SEL_W-1:0]  req_q, cur_sel;
  logic              swen_q, sw_done, busy, locked, div_load;
  logic [DIV_W-1:0]  tgt_q, div_act;
  logic [SDIV_W-1:0] sper_q;
  logic              up_q, dn_q;
  logic [NSRC-1:0]   gate_req, gate_en;
  sw_state_t         sw_state;
  logic              unused_wr;

  assign unused_wr = ^wr_data;
  assign locked    = swen_q | busy;
  assign div_load  = wr_en && !locked && wr_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      swen_q <= 1'b0;
      tgt_q  <= '0;
      sper_q <= '0;
      up_q   <= 1'b0;
      dn_q   <= 1'b0;
    end else begin
      if (sw_done) swen_q <= 1'b0;
      if (wr_en && !locked) begin
        if (!wr_sel) begin
          req_q <= wr_data[REQ_LSB +: SEL_W];
          if (wr_data[GO_BIT]) swen_q <= 1'b1;
        end else begin
          tgt_q  <= wr_data[RATIO_LSB +: DIV_W];
          sper_q <= wr_data[SPER_LSB +: SDIV_W];
          up_q   <= wr_data[UP_BIT];
          dn_q   <= wr_data[DN_BIT];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      if (!rd_sel) begin
        rd_data[CUR_LSB +: SEL_W] <= cur_sel;
        rd_data[REQ_LSB +: SEL_W] <= req_q;
        rd_data[GO_BIT]           <= swen_q;
      end else begin
        rd_data[RATIO_LSB +: DIV_W] <= tgt_q;
        rd_data[SPER_LSB +: SDIV_W] <= sper_q;
        rd_data[UP_BIT]             <= up_q;
        rd_data[DN_BIT]             <= dn_q;
        rd_data[BUSY_BIT]           <= busy;
      end
    end
  end

  sclk_switch_fsm #(.NSRC(NSRC)) u_fsm (
    .clk(clk), .rst(rst), .go(swen_q), .req_sel(req_q),
    .src_ready(src_ready), .gate_en(gate_en), .gate_req(gate_req),
    .cur_sel(cur_sel), .done(sw_done), .state(sw_state)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_gate
    sclk_gate_cell #(.OPEN_AT_RESET(i == 0)) u_cell (
      .src_clk(src_clk[i]), .rst(rst),
      .open_req(gate_req[i]), .gate_en(gate_en[i])
    );
  end

  assign sys_root_clk = |(src_clk & gate_en);

  sclk_slew_step #(.DIV_W(DIV_W), .SDIV_W(SDIV_W), .STEP_BASE(STEP_BASE)) u_slew (
    .clk(clk), .rst(rst), .load(div_load), .target(tgt_q), .per_code(sper_q),
    .up_en(up_q), .dn_en(dn_q), .ratio_act(div_act), .busy(busy)
  );

  sclk_postdiv #(.DIV_W(DIV_W)) u_div (
    .sclk(sys_root_clk), .rst(rst), .ratio_in(div_act), .out_clk(sys_clk)
  );
endmodule

// File: rtl/sclk_sw_chk.sv
`timescale 1ns/1ps
module sclk_sw_chk
  import sclk_sw_pkg::*;
#(
  parameter int NSRC = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             swen,
  input logic             done,
  input sw_state_t        state,
  input logic [SEL_W-1:0] req_sel,
  input logic [SEL_W-1:0] cur_sel,
  input logic [NSRC-1:0]  src_ready,
  input logic [NSRC-1:0]  gate_en,
  input logic             busy,
  input logic [DIV_W-1:0] div_act,
  input logic [DIV_W-1:0] tgt,
  input logic             wr_en,
  input logic             wr_sel
);
  logic req_ready;
  assign req_ready = |(src_ready & (NSRC'(1) << req_sel));

  p_onehot_gate_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gate_en));

  p_cur_change_r2: assert property (@(posedge clk) disable iff (rst)
    (cur_sel != $past(cur_sel)) |-> $past(swen));

  p_go_clears_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> ##2 !swen);

  p_reject_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (state == SW_IDLE && swen && !done && !req_ready) |=> (done && cur_sel == $past(cur_sel)));

  p_div_move_r7: assert property (@(posedge clk) disable iff (rst)
    (div_act != $past(div_act)) |-> $past(busy));

  p_busy_done_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (div_act == tgt));

  p_lock_req_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && !$past(wr_sel) && $past(swen || busy)) |-> (req_sel == $past(req_sel)));

  p_lock_tgt_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && $past(wr_sel) && $past(swen || busy)) |-> (tgt == $past(tgt)));
endmodule

bind sysclk_switcher sclk_sw_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst(rst), .swen(swen_q), .done(sw_done), .state(sw_state),
  .req_sel(req_q), .cur_sel(cur_sel), .src_ready(src_ready), .gate_en(gate_en),
  .busy(busy), .div_act(div_act), .tgt(tgt_q), .wr_en(wr_en), .wr_sel(wr_sel)
);

// File: tb/sim_sysclk_switcher.sv
`timescale 1ns/1ps
module sim_sysclk_switcher;
  localparam int NSRC = 8;
  localparam int STEP_BASE = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [NSRC-1:0] sc;
  logic [NSRC-1:0] ready = 8'b1001_1111;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [31:0] wr_data = '0, rd_data;
  logic        root, sysc;
  int checks = 0, failures = 0;
  int rc = 0;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic c = 1'b0;
    always #(3 + g) c = ~c;
    assign sc[g] = c;
  end

  sysclk_switcher #(.NSRC(NSRC), .STEP_BASE(STEP_BASE)) u0 (
    .clk(clk), .rst(rst), .src_clk(sc), .src_ready(ready),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .sys_root_clk(root), .sys_clk(sysc)
  );

  always @(posedge root) rc++;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    @(negedge clk); rd_sel = sel;
    @(negedge clk); d = rd_data;
  endtask

  task automatic wait_idle();
    logic [31:0] c, s;
    for (int k = 0; k < 2000; k++) begin
      rd(1'b0, c); rd(1'b1, s);
      if (!c[0] && !s[0]) break;
    end
  endtask

  task automatic busy_len(input logic [31:0] d, output int n);
    bit seen = 0;
    n = 0;
    rd_sel = 1'b1;
    wr(1'b1, d);
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (rd_data[0]) begin n++; seen = 1; end
      else if (seen) break;
    end
  endtask

  task automatic root_period(output realtime p);
    realtime t0;
    @(posedge root); t0 = $realtime;
    @(posedge root); p = $realtime - t0;
  endtask

  task automatic switch_to(input int s, input bit ok, input int prev);
    logic [31:0] c;
    realtime p;
    wr(1'b0, (s << 8) | 1);
    wait_idle();
    rd(1'b0, c);
    if (ok) begin
      chk(c[14:12] == 3'(s), "R2 current source after change", c[14:12], s);
      repeat (20) @(negedge clk);
      root_period(p);
      chk(p == realtime'(2 * (3 + s)), "R4 root period after change", longint'(p), 2 * (3 + s));
    end else begin
      chk(c[14:12] == 3'(prev), "R3 refused change keeps current", c[14:12], prev);
      chk(c[10:8] == 3'(s), "R3 requested field kept", c[10:8], s);
    end
    chk(c[0] == 1'b0, "R2 start bit self-clears", c[0], 0);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] c, s;
    int n, a, b;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R1 / R11 reset state
    rd(1'b0, c);
    chk(c == 32'h0, "R1 R11 control after reset", c, 0);
    rd(1'b1, s);
    chk(s == 32'h0, "R1 R11 divider after reset", s, 0);

    // R6 sweep every ratio on source 0
    for (int r = 0; r < 16; r++) begin
      wr(1'b1, r << 20);
      wait_idle();
      repeat (30) @(negedge clk);
      @(posedge sysc); #1 a = rc;
      @(posedge sysc); #1 b = rc;
      chk(b - a == r + 1, "R6 root edges per divided period", b - a, r + 1);
    end
    rd(1'b1, s);
    chk(s[23:20] == 4'd15, "R5 ratio field readback", s[23:20], 15);

    // R7 direct change and same value
    busy_len(32'h0, n);
    chk(n == 2, "R7 busy length for jump", n, 2);
    busy_len(32'h0, n);
    chk(n == 1, "R7 busy length for no change", n, 1);

    // R8 R9 slew down-scaling 0->3, code 1 (period 8)
    busy_len((3 << 20) | (1 << 8) | 32'h6, n);
    chk(n == 3 * 2 * STEP_BASE + 1, "R8 slew busy length", n, 3 * 2 * STEP_BASE + 1);
    rd(1'b1, s);
    chk(s[10:8] == 3'd1 && s[2:1] == 2'b11, "R5 slew fields readback", s[10:0], 32'h106);
    // R9 up-scaling with only down enable: jumps
    busy_len((1 << 20) | (1 << 8) | 32'h2, n);
    chk(n == 2, "R9 up-scaling without bit2 jumps", n, 2);
    // R9 up-scaling with only bit2 set, 1->0 at code 0
    busy_len((0 << 20) | 32'h4, n);
    chk(n == STEP_BASE + 1, "R9 up-scaling slews with bit2", n, STEP_BASE + 1);
    // R9 down-scaling with only bit2: jumps
    busy_len((5 << 20) | 32'h4, n);
    chk(n == 2, "R9 down-scaling without bit1 jumps", n, 2);
    // R8 down-scaling slew 5->9 code 0
    busy_len((9 << 20) | 32'h2, n);
    chk(n == 4 * STEP_BASE + 1, "R8 slew four steps", n, 4 * STEP_BASE + 1);
    busy_len(32'h0, n);
    repeat (30) @(negedge clk);

    // R10 writes during a long slew are dropped
    wr(1'b1, (4 << 20) | (7 << 8) | 32'h2);
    wr(1'b0, (3 << 8) | 1);
    wr(1'b1, 2 << 20);
    wait_idle();
    rd(1'b0, c);
    chk(c == 32'h0, "R10 control write ignored while busy", c, 0);
    rd(1'b1, s);
    chk(s[23:20] == 4'd4, "R10 divider write ignored while busy", s[23:20], 4);
    wr(1'b1, 32'h0);
    wait_idle();
    repeat (30) @(negedge clk);

    // R2 change to the source in use
    switch_to(0, 1, 0);
    // R2 R3 R4 sweep of sources
    switch_to(1, 1, 0);
    switch_to(2, 1, 1);
    switch_to(3, 1, 2);
    switch_to(4, 1, 3);
    switch_to(5, 0, 4);
    switch_to(6, 0, 4);
    switch_to(7, 1, 4);

    // R10 divider write while change pending
    wr(1'b0, (2 << 8) | 1);
    wr(1'b1, 5 << 20);
    wr(1'b0, 6 << 8);
    wait_idle();
    rd(1'b1, s);
    chk(s[23:20] == 4'd0, "R10 divider write ignored during change", s[23:20], 0);
    rd(1'b0, c);
    chk(c[10:8] == 3'd2 && c[14:12] == 3'd2, "R10 R2 change completed untouched", c, 32'h2200);
    switch_to(0, 1, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule